// File: doc/BRIEF.md
# Real-Time Clock with Posted Register Writes

The block keeps time as a 32-bit seconds count and a 32-bit fractional count. The fractional count advances on each prescaler tick while counting is enabled. When it wraps from all ones to zero, the seconds count advances. A two-word alarm (high word against seconds, low word against the fraction) raises a flag on an exact match. An all-ones high word disables the alarm.

Every register write is posted. A write is accepted only while the write path is idle, and lands a fixed number of cycles later. Status flags report busy, ready for the next write, completed write and error. A write presented while another is pending is dropped and flagged as an error. The block starts in a non-valid state: writes to the time and alarm words are refused until software clears that state. The counter also stays frozen until the seconds word has been written at least once. A single interrupt output combines four flags, each gated by its own enable bit.

The write path is a two-state machine. IDLE takes a write and moves to POSTED. POSTED counts the latency, and when the count ends it lands the write and returns to IDLE. The time base is a second two-state machine. UNSET refuses to count. UNSET moves to ARMED when a seconds write lands, and only a reset returns it to UNSET.

Top module: `rtc_posted`

## Requirements
- R1: After reset the seconds and fractional words read 0, the alarm high word reads 0xFFFFFFFF, the alarm low word reads 0, the control and interrupt-enable words read 0, the status word reads 0x00000202 (next bit 9 and non-valid bit 1), and irq is 0.
- R2: Register offsets are 0x00 seconds, 0x04 fraction, 0x08 alarm high, 0x0C alarm low, 0x10 control, 0x14 status and 0x18 interrupt enable. A write taken while status bit 9 is set makes status bit 10 (busy) read 1 and bit 9 read 0 for exactly 4 cycles. After the 4th following edge the written value is visible, bit 10 is 0, bit 9 is 1 and bit 8 (complete) is 1.
- R3: A write presented while busy is dropped. Status bit 7 (error) reads 1 from the next cycle, and the pending write still lands with its own value.
- R4: A status write that lands clears bit 7 and bit 4 where its data has a 1. Bit 8 clears when the next write is accepted and stays clear if the landing status write has data bit 8 set. Bits 1 and 0 clear only when the data has both bits 1 and 0 set.
- R5: While status bit 1 is set, writes landing at offsets 0x00 to 0x0C leave the target unchanged, set bit 7 and do not set bit 8. Writes to the control, status and enable words land normally.
- R6: While control bit 3 is set and the time base is armed, each cycle with tick high adds 1 to the fraction. When the fraction goes from 0xFFFFFFFF to 0, the seconds word also adds 1.
- R7: Until a seconds write has landed after reset, the fraction and seconds words do not count, even with control bit 3 set and tick high.
- R8: Status bit 4 (alarm) is set on the edge after the cycle in which seconds equals the alarm high word and the fraction equals the alarm low word, except when the alarm high word is 0xFFFFFFFF.
- R9: irq is high when any of these pairs is set in both the interrupt-enable word and the status word: bit 9 with next, bit 8 with complete, bit 7 with error, bit 4 with alarm.
- R10: A cycle with tamper high sets status bits 1 and 0 on the next edge.
- R11: On the edge where a seconds or fraction write lands, the counter does not tick. The written word takes the written value, and the other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for one cycle |
| waddr | input | 5 | Byte offset of the write |
| wdata | input | 32 | Write data |
| raddr | input | 5 | Byte offset of the read |
| rdata | output | 32 | Read data for raddr, from current register state |
| tick | input | 1 | Prescaler tick, one cycle wide |
| tamper | input | 1 | Security violation event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that wr_en is a one-cycle request and that tick and tamper are sampled as plain levels on each edge. They also assume that raddr has no effect on state. The stimulus changes every input only on the falling clock edge, and it presents writes both when the path is idle and, on purpose, while a write is pending, so the collision checks see real traffic. Before the alarm test, stimulus drives the fraction close to its wrap point with a write, so wrap and match are reached in a few ticks instead of counting from zero.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int DW = 32;
    localparam int AW = 5;

    localparam logic [AW-1:0] OFS_SEC  = 5'h00;
    localparam logic [AW-1:0] OFS_FRAC = 5'h04;
    localparam logic [AW-1:0] OFS_AHI  = 5'h08;
    localparam logic [AW-1:0] OFS_ALO  = 5'h0C;
    localparam logic [AW-1:0] OFS_CTRL = 5'h10;
    localparam logic [AW-1:0] OFS_STAT = 5'h14;
    localparam logic [AW-1:0] OFS_IER  = 5'h18;

    localparam int B_RUN  = 3;
    localparam int B_BUSY = 10;
    localparam int B_NEXT = 9;
    localparam int B_DONE = 8;
    localparam int B_ERR  = 7;
    localparam int B_ALM  = 4;
    localparam int B_NV   = 1;
    localparam int B_SV   = 0;

    typedef enum logic {WP_IDLE, WP_POSTED} wp_state_t;
    typedef enum logic {TB_UNSET, TB_ARMED} tb_state_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wreq_t;
endpackage

// File: rtl/rtcp_wr_post.sv
module rtcp_wr_post
    import rtcp_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          accept,
    output logic          collide,
    output logic          land,
    output wreq_t         land_req
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

    wp_state_t        st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= WP_IDLE;
            cnt      <= '0;
            land_req <= '0;
        end else begin
            unique case (st)
                WP_IDLE: begin
                    if (wr_en) begin
                        st       <= WP_POSTED;
                        cnt      <= '0;
                        land_req <= '{addr: waddr, data: wdata};
                    end
                end
                WP_POSTED: begin
                    if (cnt == CNT_LAST) st <= WP_IDLE;
                    else                 cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        busy    = 1'b0;
        accept  = 1'b0;
        collide = 1'b0;
        land    = 1'b0;
        unique case (st)
            WP_IDLE: accept = wr_en;
            WP_POSTED: begin
                busy    = 1'b1;
                collide = wr_en;
                land    = (cnt == CNT_LAST);
            end
        endcase
    end
endmodule

// File: rtl/rtcp_timebase.sv
module rtcp_timebase
    import rtcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          land_sec,
    input  logic          land_frac,
    input  logic [DW-1:0] wval,
    input  logic [DW-1:0] alarm_hi,
    input  logic [DW-1:0] alarm_lo,
    output logic [DW-1:0] sec_q,
    output logic [DW-1:0] frac_q,
    output logic          armed,
    output logic          alarm_hit
);
    tb_state_t st;
    logic      run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TB_UNSET;
        end else begin
            unique case (st)
                TB_UNSET: if (land_sec) st <= TB_ARMED;
                TB_ARMED: st <= TB_ARMED;
            endcase
        end
    end

    always_comb begin
        armed     = (st == TB_ARMED);
        run       = armed && enable && tick;
        alarm_hit = (alarm_hi != '1) && (sec_q == alarm_hi) && (frac_q == alarm_lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            frac_q <= '0;
        end else if (land_sec) begin
            sec_q <= wval;
        end else if (land_frac) begin
            frac_q <= wval;
        end else if (run) begin
            frac_q <= frac_q + 1'b1;
            if (frac_q == '1) sec_q <= sec_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_posted.sv
module rtc_posted
    import rtcp_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          tick,
    input  logic          tamper,
    output logic          irq
);
    logic          wp_busy, wp_accept, wp_collide, wp_land;
    wreq_t         land_req;
    logic [AW-1:0] land_addr;
    logic [DW-1:0] land_data;
    logic          prot_addr, land_rej, land_ok, land_sec, land_frac, stat_w;
    logic [DW-1:0] sec_q, frac_q, alarm_hi, alarm_lo;
    logic          tb_armed, alarm_hit;
    logic          ctrl_run;
    logic          ie_next, ie_done, ie_err, ie_alm;
    logic          f_done, f_err, f_alm, f_nv, f_sv;
    logic [DW-1:0] stat_word, ctrl_word, ier_word;

    rtcp_wr_post #(.LAT(LAT)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .waddr    (waddr),
        .wdata    (wdata),
        .busy     (wp_busy),
        .accept   (wp_accept),
        .collide  (wp_collide),
        .land     (wp_land),
        .land_req (land_req)
    );

    always_comb begin
        land_addr = land_req.addr;
        land_data = land_req.data;
        prot_addr = (land_addr == OFS_SEC) || (land_addr == OFS_FRAC) ||
                    (land_addr == OFS_AHI) || (land_addr == OFS_ALO);
        land_rej  = wp_land && f_nv && prot_addr;
        land_ok   = wp_land && !land_rej;
        land_sec  = land_ok && (land_addr == OFS_SEC);
        land_frac = land_ok && (land_addr == OFS_FRAC);
        stat_w    = land_ok && (land_addr == OFS_STAT);
    end

    rtcp_timebase u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (ctrl_run),
        .land_sec  (land_sec),
        .land_frac (land_frac),
        .wval      (land_data),
        .alarm_hi  (alarm_hi),
        .alarm_lo  (alarm_lo),
        .sec_q     (sec_q),
        .frac_q    (frac_q),
        .armed     (tb_armed),
        .alarm_hit (alarm_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_hi <= '1;
            alarm_lo <= '0;
            ctrl_run <= 1'b0;
            ie_next  <= 1'b0;
            ie_done  <= 1'b0;
            ie_err   <= 1'b0;
            ie_alm   <= 1'b0;
        end else if (land_ok) begin
            unique case (land_addr)
                OFS_AHI:  alarm_hi <= land_data;
                OFS_ALO:  alarm_lo <= land_data;
                OFS_CTRL: ctrl_run <= land_data[B_RUN];
                OFS_IER: begin
                    ie_next <= land_data[B_NEXT];
                    ie_done <= land_data[B_DONE];
                    ie_err  <= land_data[B_ERR];
                    ie_alm  <= land_data[B_ALM];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_done <= 1'b0;
            f_err  <= 1'b0;
            f_alm  <= 1'b0;
            f_nv   <= 1'b1;
            f_sv   <= 1'b0;
        end else begin
            if (wp_accept)
                f_done <= 1'b0;
            else if (land_ok && !(stat_w && land_data[B_DONE]))
                f_done <= 1'b1;

            if (wp_collide || land_rej)
                f_err <= 1'b1;
            else if (stat_w && land_data[B_ERR])
                f_err <= 1'b0;

            if (alarm_hit)
                f_alm <= 1'b1;
            else if (stat_w && land_data[B_ALM])
                f_alm <= 1'b0;

            if (tamper) begin
                f_nv <= 1'b1;
                f_sv <= 1'b1;
            end else if (stat_w && land_data[B_NV] && land_data[B_SV]) begin
                f_nv <= 1'b0;
                f_sv <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_word         = '0;
        stat_word[B_BUSY] = wp_busy;
        stat_word[B_NEXT] = !wp_busy;
        stat_word[B_DONE] = f_done;
        stat_word[B_ERR]  = f_err;
        stat_word[B_ALM]  = f_alm;
        stat_word[B_NV]   = f_nv;
        stat_word[B_SV]   = f_sv;

        ctrl_word         = '0;
        ctrl_word[B_RUN]  = ctrl_run;

        ier_word          = '0;
        ier_word[B_NEXT]  = ie_next;
        ier_word[B_DONE]  = ie_done;
        ier_word[B_ERR]   = ie_err;
        ier_word[B_ALM]   = ie_alm;

        case (raddr)
            OFS_SEC:  rdata = sec_q;
            OFS_FRAC: rdata = frac_q;
            OFS_AHI:  rdata = alarm_hi;
            OFS_ALO:  rdata = alarm_lo;
            OFS_CTRL: rdata = ctrl_word;
            OFS_STAT: rdata = stat_word;
            OFS_IER:  rdata = ier_word;
            default:  rdata = '0;
        endcase

        irq = (ie_next && !wp_busy) || (ie_done && f_done) ||
              (ie_err && f_err) || (ie_alm && f_alm);
    end
endmodule

// File: rtl/rtc_posted_chk.sv
module rtc_posted_chk
    import rtcp_pkg::*;
#(
    parameter int LAT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          tamper,
    input logic          busy,
    input logic          land,
    input logic [AW-1:0] land_addr,
    input logic          land_frac,
    input logic          armed,
    input logic [DW-1:0] frac_q,
    input logic [DW-1:0] alarm_hi,
    input logic          f_err,
    input logic          f_alm,
    input logic          f_nv,
    input logic          f_sv
);
    localparam int RW = $clog2(LAT + 2) + 1;
    logic [RW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_run <= '0;
        else if (busy)  busy_run <= busy_run + 1'b1;
        else            busy_run <= '0;
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RW'(LAT)); // R2

    AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> f_err); // R3

    AST_NV_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (land && f_nv && land_addr == OFS_AHI) |=> $stable(alarm_hi)); // R5

    AST_UNSET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !land_frac) |=> $stable(frac_q)); // R7

    AST_ALARM_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hi == '1 && !f_alm) |=> !f_alm); // R8

    AST_TAMPER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tamper |=> (f_nv && f_sv)); // R10
endmodule

bind rtc_posted rtc_posted_chk #(.LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .tamper    (tamper),
    .busy      (wp_busy),
    .land      (wp_land),
    .land_addr (land_addr),
    .land_frac (land_frac),
    .armed     (tb_armed),
    .frac_q    (frac_q),
    .alarm_hi  (alarm_hi),
    .f_err     (f_err),
    .f_alm     (f_alm),
    .f_nv      (f_nv),
    .f_sv      (f_sv)
);

// File: tb/rtc_posted_tb.sv
`timescale 1ns/1ps
module rtc_posted_tb;
    localparam bit [4:0] A_SEC = 5'h00, A_FRAC = 5'h04, A_AHI = 5'h08, A_ALO = 5'h0C;
    localparam bit [4:0] A_CTRL = 5'h10, A_STAT = 5'h14, A_IER = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  raddr = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        tamper = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_posted u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .tick(tick), .tamper(tamper), .irq(irq)
    );

    // behavioural reference
    bit [31:0] m_sec, m_frac, m_ahi, m_alo, m_qd;
    bit        m_run, m_armed, m_done, m_err, m_alm, m_nv, m_sv, m_pend;
    bit [3:0]  m_ie;
    bit [4:0]  m_qa;
    int        m_left;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_frac = 0; m_ahi = 32'hFFFFFFFF; m_alo = 0;
            m_run = 0; m_armed = 0; m_done = 0; m_err = 0; m_alm = 0;
            m_nv = 1; m_sv = 0; m_pend = 0; m_left = 0; m_ie = 0;
            m_qa = 0; m_qd = 0;
        end else begin
            bit landx, coll, acc, rej, hit, stw;
            bit [31:0] ns, nf;
            landx = m_pend && (m_left == 1);
            coll  = m_pend && wr_en;
            acc   = !m_pend && wr_en;
            rej   = landx && m_nv && (m_qa < 5'h10);
            hit   = (m_ahi != 32'hFFFFFFFF) && (m_sec == m_ahi) && (m_frac == m_alo);
            stw   = landx && !rej && (m_qa == A_STAT);
            ns = m_sec; nf = m_frac;
            if (m_armed && m_run && tick) begin
                nf = m_frac + 1;
                if (m_frac == 32'hFFFFFFFF) ns = m_sec + 1;
            end
            if (acc) m_done = 0;
            else if (landx && !rej && !(stw && m_qd[8])) m_done = 1;
            if (coll || rej) m_err = 1;
            else if (stw && m_qd[7]) m_err = 0;
            if (hit) m_alm = 1;
            else if (stw && m_qd[4]) m_alm = 0;
            if (tamper) begin m_nv = 1; m_sv = 1; end
            else if (stw && m_qd[1] && m_qd[0]) begin m_nv = 0; m_sv = 0; end
            if (landx && !rej) begin
                case (m_qa)
                    A_SEC:  begin ns = m_qd; nf = m_frac; m_armed = 1; end
                    A_FRAC: begin nf = m_qd; ns = m_sec; end
                    A_AHI:  m_ahi = m_qd;
                    A_ALO:  m_alo = m_qd;
                    A_CTRL: m_run = m_qd[3];
                    A_IER:  m_ie = {m_qd[9], m_qd[8], m_qd[7], m_qd[4]};
                    default: ;
                endcase
            end
            m_sec = ns; m_frac = nf;
            if (landx) m_pend = 0;
            else if (m_pend) m_left = m_left - 1;
            if (acc) begin m_pend = 1; m_left = 4; m_qa = waddr; m_qd = wdata; end
        end
    end

    function automatic bit [31:0] mread(bit [4:0] ra);
        case (ra)
            A_SEC:  return m_sec;
            A_FRAC: return m_frac;
            A_AHI:  return m_ahi;
            A_ALO:  return m_alo;
            A_CTRL: return {28'b0, m_run, 3'b0};
            A_STAT: return {21'b0, m_pend, !m_pend, m_done, m_err, 2'b0, m_alm, 2'b0, m_nv, m_sv};
            A_IER:  return {22'b0, m_ie[3], m_ie[2], m_ie[1], 2'b0, m_ie[0], 4'b0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(bit [4:0] ra);
        case (ra)
            A_SEC, A_FRAC: return "R6";
            A_AHI, A_ALO:  return "R8";
            A_CTRL:        return "R2";
            A_STAT:        return "R4";
            A_IER:         return "R9";
            default:       return "R1";
        endcase
    endfunction

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit [31:0] e;
            bit ei;
            e  = mread(raddr);
            ei = (m_ie[3] && !m_pend) || (m_ie[2] && m_done) || (m_ie[1] && m_err) || (m_ie[0] && m_alm);
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s model compare addr=%h got=%h exp=%h", tag_of(raddr), raddr, rdata, e);
            end
            checks++;
            if (irq !== ei) begin
                errors++;
                $display("FAIL R9 model compare irq got=%b exp=%b", irq, ei);
            end
        end
    end

    task automatic chk(string tag, bit [31:0] got, bit [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic cyc(bit w, bit [4:0] a, bit [31:0] d, bit [4:0] ra, bit tk, bit tp);
        @(negedge clk);
        wr_en = w; waddr = a; wdata = d; raddr = ra; tick = tk; tamper = tp;
        #1;
    endtask

    task automatic rd(bit [4:0] ra);
        cyc(0, 5'h0, 32'h0, ra, 0, 0);
    endtask

    task automatic wr_wait(bit [4:0] a, bit [31:0] d);
        cyc(1, a, d, A_STAT, 0, 0);
        repeat (4) rd(A_STAT);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT); chk("R1 status", rdata, 32'h202); chk("R1 irq", {31'b0, irq}, 0);
        rd(A_AHI);  chk("R1 alarm high", rdata, 32'hFFFFFFFF);
        rd(A_SEC);  chk("R1 seconds", rdata, 0);

        // R2 posted write timing, control lands while non-valid (R5)
        cyc(1, A_CTRL, 32'h8, A_STAT, 0, 0);
        for (int i = 0; i < 4; i++) begin
            rd(A_STAT); chk("R2 busy window", rdata & 32'h600, 32'h400);
        end
        rd(A_STAT); chk("R2 landed status", rdata, 32'h302);
        rd(A_CTRL); chk("R2 control value", rdata, 32'h8);

        // R5 protected write refused while non-valid; R4 complete cleared on accept
        cyc(1, A_SEC, 32'd100, A_STAT, 0, 0);
        rd(A_STAT); chk("R4 complete cleared on accept", rdata & 32'h100, 0);
        repeat (3) rd(A_STAT);
        rd(A_SEC);  chk("R5 seconds unchanged", rdata, 0);
        rd(A_STAT); chk("R5 error no complete", rdata, 32'h282);

        // R7 no counting before a seconds write
        repeat (10) cyc(0, 5'h0, 0, A_FRAC, 1, 0);
        rd(A_FRAC); chk("R7 fraction frozen", rdata, 0);

        // R4 single non-valid bit does not clear; both do
        wr_wait(A_STAT, 32'h2);
        rd(A_STAT); chk("R4 single bit keeps non-valid", rdata, 32'h382);
        wr_wait(A_STAT, 32'h83);
        rd(A_STAT); chk("R4 clear error and non-valid", rdata, 32'h300);

        // R3 write while busy
        cyc(1, A_SEC, 32'd5, A_STAT, 0, 0);
        cyc(1, A_FRAC, 32'd7, A_STAT, 0, 0);
        rd(A_STAT); chk("R3 error after collision", rdata & 32'h480, 32'h480);
        repeat (2) rd(A_STAT);
        rd(A_SEC);  chk("R3 pending write landed", rdata, 5);
        rd(A_FRAC); chk("R3 dropped write absent", rdata, 0);

        // R6 counting and wrap
        wr_wait(A_FRAC, 32'hFFFFFFFE);
        cyc(0, 5'h0, 0, A_FRAC, 1, 0);
        cyc(0, 5'h0, 0, A_FRAC, 1, 0);
        rd(A_FRAC); chk("R6 fraction wrapped", rdata, 0);
        rd(A_SEC);  chk("R6 seconds carried", rdata, 6);

        // R11 landing seconds suppresses the tick on that edge
        cyc(1, A_SEC, 32'd50, A_FRAC, 1, 0);
        repeat (4) cyc(0, 5'h0, 0, A_FRAC, 1, 0);
        rd(A_SEC);  chk("R11 seconds written", rdata, 50);
        rd(A_FRAC); chk("R11 fraction ticks", rdata, 4);

        // R8 alarm match, one edge later
        wr_wait(A_AHI, 32'd50);
        wr_wait(A_ALO, 32'd10);
        repeat (6) cyc(0, 5'h0, 0, A_FRAC, 1, 0);
        rd(A_STAT); chk("R8 alarm not yet", rdata & 32'h10, 0);
        rd(A_STAT); chk("R8 alarm set", rdata & 32'h10, 32'h10);
        wr_wait(A_IER, 32'h10);
        rd(A_STAT); chk("R9 irq from alarm", {31'b0, irq}, 1);
        cyc(0, 5'h0, 0, A_FRAC, 1, 0);
        wr_wait(A_STAT, 32'h10);
        rd(A_STAT); chk("R4 alarm cleared", rdata, 32'h380);
        chk("R9 irq dropped", {31'b0, irq}, 0);

        // R8 all-ones high word never matches
        wr_wait(A_SEC, 32'hFFFFFFFF);
        wr_wait(A_AHI, 32'hFFFFFFFF);
        wr_wait(A_ALO, 32'd11);
        rd(A_STAT); rd(A_STAT); chk("R8 never alarm", rdata & 32'h10, 0);

        // R10 tamper, R9 error interrupt
        cyc(0, 5'h0, 0, A_STAT, 0, 1);
        rd(A_STAT); chk("R10 tamper flags", rdata, 32'h383);
        wr_wait(A_IER, 32'h80);
        rd(A_STAT); chk("R9 irq from error", {31'b0, irq}, 1);

        repeat (2) rd(A_STAT);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule